// File: doc/BRIEF.md
# GPIO Pin Interrupt Controller

This block turns the twelve inputs of a general-purpose port into interrupt requests. Every input passes through a synchroniser. It is then judged against a per-pin event rule. The rule is either a level (high or low) or an edge (rising, falling, or both). Edge events are caught in a sticky flag. Level events track the input as long as it stays at the chosen level.

Software programs the rules and reads status through a simple 32-bit register bus. A write strobe with a byte address stores write data on the rising clock edge. Read data follows the address combinationally. Software can read a raw status that ignores the enable bits, and a masked status that honours them. It removes caught edges by writing ones to a clear register. Each pin has its own interrupt output, and one combined line is the OR of all masked pins.

Register offsets: 0x04 polarity, 0x08 both-edges, 0x0C sense, 0x10 enable, 0x14 raw status, 0x18 masked status, 0x1C clear. Bit i of each register belongs to pin i.

Top module: `gpio_pin_irq`

## Requirements
- R1: After reset, every register reads 0, and all interrupt outputs are low.
- R2: Bits 31:12 of every read are 0. Offsets outside the map read 0, and the clear register (0x1C) always reads 0.
- R3: Enable (0x10) is read/write. A pin whose enable bit is 0 never drives its interrupt output.
- R4: Masked status (0x18) equals raw status AND enable. `pin_irq[i]` equals masked bit i.
- R5: `port_irq` is high exactly when any masked bit is set. Enabling a pin that already has a pending caught edge raises its interrupt at once.
- R6: Raw status (0x14) is reported whatever the enable bits hold.
- R7: With sense bit 0 (edge), polarity bit 1 catches rising edges, and polarity bit 0 catches falling edges. The opposite edge is ignored. A caught edge stays set until it is cleared.
- R8: With both-edges bit 1, an edge pin catches either transition, whatever its polarity bit.
- R9: Writing 1 to a clear bit removes that pin's caught edge. Clear bits written as 0 leave their pins untouched.
- R10: With sense bit 1 (level), the raw bit is 1 while the synchronised input equals the polarity bit. Clear writes have no effect. No caught edge survives a return to edge mode.
- R11: If a new edge and a clear write for the same pin arrive in the same cycle, the raw bit stays set.
- R12: Consider an input change applied between clock edges. An edge pin's raw bit is still 0 after the second following rising edge and is 1 after the third.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 12 | Asynchronous port inputs |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pin_irq | output | 12 | Per-pin masked interrupt |
| port_irq | output | 1 | OR of all masked interrupts |

## Verification
The bench walks a rising edge across every pin in turn, with the mask closed. This separates raw from masked status, and it pins down the synchroniser latency cycle by cycle. It then drops all twelve inputs at once under falling polarity and applies a checkerboard enable, so that a per-bit mix-up between enable, raw and masked shows up. Further patterns cover both-edges mode with partial pin groups, ignored opposite edges, level mode under a mixed polarity word with a clear write that must not act, and an edge timed to meet a clear write in the same cycle.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
   localparam int unsigned OFS_POL   = 'h04;
   localparam int unsigned OFS_BOTH  = 'h08;
   localparam int unsigned OFS_SENSE = 'h0C;
   localparam int unsigned OFS_EN    = 'h10;
   localparam int unsigned OFS_RAW   = 'h14;
   localparam int unsigned OFS_MIS   = 'h18;
   localparam int unsigned OFS_CLR   = 'h1C;
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
   parameter int unsigned WIDTH  = 12,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_irq_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) chain[s] <= '0;
      end else begin
         chain[0] <= d;
         for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
   parameter int unsigned NPINS = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPINS-1:0] lvl,
   input  logic [NPINS-1:0] pol,
   input  logic [NPINS-1:0] both,
   input  logic [NPINS-1:0] sense,
   input  logic [NPINS-1:0] clr,
   output logic [NPINS-1:0] edge_lat,
   output logic [NPINS-1:0] raw
);
   logic [NPINS-1:0] prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= '0;
      else        prev <= lvl;
   end

   for (genvar g = 0; g < NPINS; g++) begin : g_pin
      logic rise, fall, hit;
      assign rise = lvl[g] & ~prev[g];
      assign fall = ~lvl[g] & prev[g];
      assign hit  = both[g] ? (rise | fall) : (pol[g] ? rise : fall);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        edge_lat[g] <= 1'b0;
         else if (sense[g]) edge_lat[g] <= 1'b0;
         else if (hit)      edge_lat[g] <= 1'b1;
         else if (clr[g])   edge_lat[g] <= 1'b0;
      end

      assign raw[g] = sense[g] ? ~(lvl[g] ^ pol[g]) : edge_lat[g];
   end
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
   import gpio_irq_pkg::*;
#(
   parameter int unsigned NPINS  = 12,
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic [NPINS-1:0]  raw,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [NPINS-1:0]  pol_q,
   output logic [NPINS-1:0]  both_q,
   output logic [NPINS-1:0]  sense_q,
   output logic [NPINS-1:0]  en_q,
   output logic [NPINS-1:0]  clr
);
   localparam logic [ADDR_W-1:0] A_POL   = ADDR_W'(OFS_POL);
   localparam logic [ADDR_W-1:0] A_BOTH  = ADDR_W'(OFS_BOTH);
   localparam logic [ADDR_W-1:0] A_SENSE = ADDR_W'(OFS_SENSE);
   localparam logic [ADDR_W-1:0] A_EN    = ADDR_W'(OFS_EN);
   localparam logic [ADDR_W-1:0] A_RAW   = ADDR_W'(OFS_RAW);
   localparam logic [ADDR_W-1:0] A_MIS   = ADDR_W'(OFS_MIS);
   localparam logic [ADDR_W-1:0] A_CLR   = ADDR_W'(OFS_CLR);

   logic [NPINS-1:0] wbits;
   assign wbits = bus_wdata[NPINS-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pol_q   <= '0;
         both_q  <= '0;
         sense_q <= '0;
         en_q    <= '0;
      end else if (bus_wr) begin
         if (bus_addr == A_POL)   pol_q   <= wbits;
         if (bus_addr == A_BOTH)  both_q  <= wbits;
         if (bus_addr == A_SENSE) sense_q <= wbits;
         if (bus_addr == A_EN)    en_q    <= wbits;
      end
   end

   assign clr = (bus_wr && bus_addr == A_CLR) ? wbits : '0;

   logic [NPINS-1:0] rsel;
   always_comb begin
      case (bus_addr)
         A_POL:   rsel = pol_q;
         A_BOTH:  rsel = both_q;
         A_SENSE: rsel = sense_q;
         A_EN:    rsel = en_q;
         A_RAW:   rsel = raw;
         A_MIS:   rsel = raw & en_q;
         default: rsel = '0;
      endcase
      bus_rdata = '0;
      bus_rdata[NPINS-1:0] = rsel;
   end
endmodule

// File: rtl/gpio_pin_irq.sv
module gpio_pin_irq #(
   parameter int unsigned NPINS       = 12,
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NPINS-1:0]  pin_in,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [NPINS-1:0]  pin_irq,
   output logic              port_irq
);
   if (NPINS < 1 || NPINS > DATA_W) begin : g_bad_npins
      $error("gpio_pin_irq: NPINS must lie in 1..DATA_W");
   end
   if (ADDR_W < 5) begin : g_bad_addr
      $error("gpio_pin_irq: ADDR_W too small for the register map");
   end

   logic [NPINS-1:0] lvl, raw, edge_lat, clr_mask;
   logic [NPINS-1:0] pol_q, both_q, sense_q, en_q;

   gpio_irq_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_in), .q(lvl)
   );

   gpio_irq_detect #(.NPINS(NPINS)) u_detect (
      .clk(clk), .rst_n(rst_n), .lvl(lvl), .pol(pol_q), .both(both_q),
      .sense(sense_q), .clr(clr_mask), .edge_lat(edge_lat), .raw(raw)
   );

   gpio_irq_regs #(.NPINS(NPINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .raw(raw), .bus_rdata(bus_rdata),
      .pol_q(pol_q), .both_q(both_q), .sense_q(sense_q), .en_q(en_q),
      .clr(clr_mask)
   );

   assign pin_irq  = raw & en_q;
   assign port_irq = |pin_irq;
endmodule

// File: rtl/gpio_pin_irq_chk.sv
module gpio_pin_irq_chk #(
   parameter int unsigned NPINS  = 12,
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NPINS-1:0]  pin_irq,
   input logic              port_irq,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_rdata,
   input logic [NPINS-1:0]  en,
   input logic [NPINS-1:0]  sense,
   input logic [NPINS-1:0]  lat,
   input logic [NPINS-1:0]  clr
);
   a_r5_port_or: assert property (@(posedge clk) disable iff (!rst_n)
      port_irq == ($countones(pin_irq) != 0));

   a_r3_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_irq & ~en) == '0);

   a_r7_edge_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (lat & $past(lat & ~clr & ~sense)) == $past(lat & ~clr & ~sense));

   a_r2_clear_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADDR_W'('h1C)) |-> (bus_rdata == '0));

   if (NPINS < DATA_W) begin : g_resv
      a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
         bus_rdata[DATA_W-1:NPINS] == '0);
   end
endmodule

bind gpio_pin_irq gpio_pin_irq_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .pin_irq(pin_irq), .port_irq(port_irq),
   .bus_addr(bus_addr), .bus_rdata(bus_rdata), .en(en_q), .sense(sense_q),
   .lat(edge_lat), .clr(clr_mask)
);

// File: tb/test_gpio_pin_irq.sv
`timescale 1ns/1ps
module test_gpio_pin_irq;
   localparam int N = 12;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [N-1:0] pin_in = '0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [N-1:0] pin_irq;
   logic        port_irq;
   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   gpio_pin_irq i_gpio_pin_irq (
      .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pin_irq(pin_irq), .port_irq(port_irq)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic rdchk(input string req, input logic [7:0] a, input logic [31:0] exp);
      bus_addr = a;
      #1;
      check(req, bus_rdata, exp);
   endtask

   task automatic drive(input logic [N-1:0] v);
      @(negedge clk);
      pin_in = v;
      repeat (4) @(negedge clk);
   endtask

   initial begin
      #500000;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      for (int a = 4; a <= 'h1C; a += 4) rdchk("R1 reset reg", 8'(a), 32'h0);
      check("R1 pin_irq", 32'(pin_irq), 0);
      check("R1 port_irq", 32'(port_irq), 0);
      // R2 / R3 register access
      wr('h10, 32'hFFFF_FFFF);
      rdchk("R3 enable readback", 'h10, 32'h0000_0FFF);
      rdchk("R2 unmapped 0x00", 'h00, 0);
      rdchk("R2 unmapped 0x20", 'h20, 0);
      rdchk("R2 clear reads zero", 'h1C, 0);
      wr('h10, 0);
      // R7 / R12 rising sweep over every pin, masked
      wr('h04, 32'hFFF);
      for (int i = 0; i < N; i++) begin
         @(negedge clk);
         pin_in[i] = 1'b1;
         @(posedge clk); @(posedge clk); @(negedge clk);
         rdchk("R12 not yet latched", 'h14, 0);
         @(posedge clk); @(negedge clk);
         rdchk("R7 rising caught", 'h14, 32'(1) << i);
         check("R3 masked pin silent", 32'(pin_irq), 0);
         rdchk("R4 masked status zero", 'h18, 0);
         check("R5 port idle", 32'(port_irq), 0);
         wr('h1C, 32'(1) << i);
         rdchk("R9 clear removes", 'h14, 0);
      end
      // falling polarity, all pins together, checkerboard enable
      wr('h04, 0);
      drive('0);
      rdchk("R7 falling caught", 'h14, 32'hFFF);
      wr('h10, 32'hA5A);
      check("R4 pin_irq mix", 32'(pin_irq), 32'hA5A);
      check("R5 port active", 32'(port_irq), 1);
      rdchk("R4 masked read", 'h18, 32'hA5A);
      rdchk("R6 raw unmasked", 'h14, 32'hFFF);
      wr('h1C, 32'h0F0);
      rdchk("R9 zero bits untouched", 'h14, 32'hF0F);
      wr('h1C, 32'hFFF);
      check("R5 port drops", 32'(port_irq), 0);
      // R8 both edges
      wr('h08, 32'hFFF);
      drive(12'h00F);
      rdchk("R8 rise with pol 0", 'h14, 32'h00F);
      wr('h1C, 32'hFFF);
      drive('0);
      rdchk("R8 fall caught", 'h14, 32'h00F);
      wr('h1C, 32'hFFF);
      wr('h08, 0);
      drive(12'h0F0);
      rdchk("R7 opposite edge ignored", 'h14, 0);
      // R10 level mode
      wr('h04, 32'h0F0);
      wr('h0C, 32'hFFF);
      rdchk("R10 level match", 'h14, 32'hFFF);
      drive(12'h3C3);
      rdchk("R10 level follows", 'h14, 32'hCCC);
      wr('h1C, 32'hFFF);
      rdchk("R10 clear no effect", 'h14, 32'hCCC);
      check("R4 level masked", 32'(pin_irq), 32'h848);
      // R11 edge meets clear
      wr('h08, 32'h001);
      wr('h0C, 0);
      rdchk("R10 no stale latch", 'h14, 0);
      drive(12'h3C2);
      rdchk("R8 pin0 fall", 'h14, 32'h001);
      @(negedge clk);
      pin_in = 12'h3C3;
      @(posedge clk); @(posedge clk); @(negedge clk);
      bus_wr = 1'b1; bus_addr = 'h1C; bus_wdata = 32'h001;
      @(posedge clk); @(negedge clk);
      bus_wr = 1'b0; bus_wdata = '0;
      rdchk("R11 edge beats clear", 'h14, 32'h001);
      wr('h1C, 32'h001);
      rdchk("R9 later clear", 'h14, 0);
      // R5 unmask with pending edge
      wr('h10, 0);
      drive(12'h3C2);
      check("R5 masked pending idle", 32'(port_irq), 0);
      rdchk("R6 pending visible", 'h14, 32'h001);
      wr('h10, 32'h001);
      check("R5 unmask immediate pin", 32'(pin_irq), 32'h001);
      check("R5 unmask immediate port", 32'(port_irq), 1);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule